// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Meter

This block measures how fast an unknown clock runs. It opens a gate that lasts a programmed number of reference-clock cycles and counts the rising edges of the measured clock while the gate is open. It then computes an optional rate in kHz as `REF_KHZ * count / window`.

The gate timing and the configuration port sit in the reference domain. The edge counter sits in the measured-clock domain. The gate and clear levels reach the counter through two-stage synchronizers. A done level comes back through another synchronizer. The count bus is only taken into the reference domain after it has held the same value for two consecutive reference cycles.

Once a result is published it does not change until the next clear or start. Two reads taken at different times therefore agree, and software can use that agreement to confirm the measurement has settled. A read that disagrees means a measurement is still in progress.

Top module: `refgated_freq_meter`

## Requirements
- R1: After reset, `busy`, `countValid` and `freqValid` are low, `countOut` is zero, and the window length is 100 reference cycles.
- R2: A configuration write with bit 0 (clear) set aborts any measurement and zeroes the measured-clock counter. On the following cycle `countValid` and `freqValid` are low and `countOut` is zero.
- R3: On a write with clear low, the window field `cfgData[WIN_W+2:3]` is loaded only when bit 2 (window write enable) is set and the field is non-zero. Otherwise the stored window is kept. A write that sets only bit 2 does not start a measurement.
- R4: A write with clear low and bit 1 (enable) set starts a measurement when the block is not busy. The result is the number of measured-clock rising edges during a gate of exactly the window length in reference cycles. With a 250 MHz measured clock and a 100 MHz reference, this is 2.5 × window.
- R5: `busy` is high from the cycle after a start until the result is published. It is never high together with `countValid`. Any write without clear that arrives while busy is ignored entirely.
- R6: After `countValid` rises, `countOut` holds its value until the next clear or start write, so two reads at different times return the same value.
- R7: A start with no clear since the previous measurement leaves the frozen counter untouched and publishes the same count again.
- R8: The measured-clock counter stops at all ones instead of wrapping.
- R9: After each published count, `freqValid` rises with `freqKhz = floor(REF_KHZ * count / window)`, capped at all ones of `FREQ_W`. `freqValid` is never high without `countValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock; times the window and runs the configuration port |
| measClk | input | 1 | Clock whose rate is measured |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| cfgWrite | input | 1 | Configuration write strobe, one reference cycle |
| cfgData | input | WIN_W+3 | Bit 0 clear, bit 1 enable, bit 2 window write enable, upper bits window length |
| busy | output | 1 | Measurement in progress |
| countValid | output | 1 | `countOut` holds a settled result |
| countOut | output | COUNT_W | Published edge count |
| freqValid | output | 1 | `freqKhz` holds the rate for the published count |
| freqKhz | output | FREQ_W | Measured rate in kHz |

## Verification
The assertions check five behaviours on every cycle:
- `busy` and `countValid` are never both high.
- The published count is held while no write occurs.
- A clear write empties the result on the next cycle.
- A valid rate never appears without a valid count.
- A saturated counter stays saturated in the measured domain.

The exact edge count for a window, the default and retained window lengths, the rejection of writes during a run, the repeated result on a restart without a clear, and the computed kHz value depend on the two clock phases. Only the bench's scenarios can show them, and it does so against a 2.5:1 clock ratio whose expected counts it derives on its own.

// File: rtl/freqmeter_pkg.sv
package freqmeter_pkg;

  // level controls carried from the reference domain to the counter domain
  typedef struct packed {
    logic clear;
    logic gate;
  } measCtl_t;

  // single-cycle strobes from the sequencer to the rate calculator
  typedef struct packed {
    logic start;
    logic flush;
  } calcCtl_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GATE,
    PH_DRAIN,
    PH_SETTLE,
    PH_DONE
  } phase_t;

  localparam int CFG_CLR_BIT = 0;
  localparam int CFG_EN_BIT  = 1;
  localparam int CFG_WE_BIT  = 2;
  localparam int CFG_WIN_LSB = 3;

endpackage

// File: rtl/freqmeter_sync.sv
module freqmeter_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/freqmeter_ctrl.sv
module freqmeter_ctrl
  import freqmeter_pkg::*;
#(
  parameter int COUNT_W     = 32,
  parameter int WIN_W       = 16,
  parameter int DEF_WINDOW  = 100,
  parameter int SETTLE_CYC  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               refClk,
  input  logic               rstN,
  input  logic               cfgWrite,
  input  logic [WIN_W+2:0]   cfgData,
  input  logic               measDone,
  input  logic [COUNT_W-1:0] measCount,
  output measCtl_t           measCtl,
  output calcCtl_t           calcCtl,
  output logic               busy,
  output logic               countValid,
  output logic [COUNT_W-1:0] countOut,
  output logic [WIN_W-1:0]   activeWin
);

  localparam int STL_W = $clog2(SETTLE_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_RESET = WIN_W'(DEF_WINDOW);

  phase_t             phase;
  logic [WIN_W-1:0]   windowReg;
  logic [WIN_W-1:0]   winCnt;
  logic               gateLvl;
  logic               clearLvl;
  logic               sawLow;
  logic [COUNT_W-1:0] countSample;
  logic [STL_W-1:0]   stableCnt;
  logic               startPulse;
  logic               doneS;

  // write decode
  logic [WIN_W-1:0] winField;
  logic             wrClear;
  logic             wrStart;
  logic             loadOk;
  logic             idleLike;
  logic             startGo;
  logic             capture;
  logic [WIN_W-1:0] nextWin;

  freqmeter_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) doneSync_i (
    .clk (refClk),
    .rstN(rstN),
    .din (measDone),
    .dout(doneS)
  );

  always_comb begin
    winField = cfgData[CFG_WIN_LSB +: WIN_W];
    wrClear  = cfgWrite && cfgData[CFG_CLR_BIT];
    wrStart  = cfgWrite && !cfgData[CFG_CLR_BIT] && cfgData[CFG_EN_BIT];
    loadOk   = cfgWrite && !cfgData[CFG_CLR_BIT] && cfgData[CFG_WE_BIT] && (winField != '0);
    idleLike = (phase == PH_IDLE) || (phase == PH_DONE);
    startGo  = wrStart && idleLike;
    nextWin  = loadOk ? winField : windowReg;
    capture  = (phase == PH_SETTLE) && (measCount == countSample) &&
               (stableCnt == STL_W'(SETTLE_CYC - 1));
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      windowReg   <= WIN_RESET;
      activeWin   <= WIN_RESET;
      winCnt      <= '0;
      gateLvl     <= 1'b0;
      clearLvl    <= 1'b0;
      sawLow      <= 1'b0;
      countSample <= '0;
      stableCnt   <= '0;
      countOut    <= '0;
      countValid  <= 1'b0;
      startPulse  <= 1'b0;
    end else begin
      startPulse <= 1'b0;
      if (wrClear) begin
        phase      <= PH_IDLE;
        gateLvl    <= 1'b0;
        clearLvl   <= 1'b1;
        countValid <= 1'b0;
        countOut   <= '0;
        stableCnt  <= '0;
      end else begin
        if (loadOk && idleLike) windowReg <= winField;
        unique case (phase)
          PH_IDLE, PH_DONE: begin
            if (wrStart) begin
              activeWin  <= nextWin;
              winCnt     <= nextWin;
              gateLvl    <= 1'b1;
              clearLvl   <= 1'b0;
              countValid <= 1'b0;
              sawLow     <= 1'b0;
              phase      <= PH_GATE;
            end
          end
          PH_GATE: begin
            if (!doneS) sawLow <= 1'b1;
            winCnt <= winCnt - 1'b1;
            if (winCnt == WIN_W'(1)) begin
              gateLvl <= 1'b0;
              phase   <= PH_DRAIN;
            end
          end
          PH_DRAIN: begin
            if (!doneS) sawLow <= 1'b1;
            if (doneS && sawLow) begin
              countSample <= measCount;
              stableCnt   <= '0;
              phase       <= PH_SETTLE;
            end
          end
          PH_SETTLE: begin
            countSample <= measCount;
            if (measCount != countSample) begin
              stableCnt <= '0;
            end else if (capture) begin
              countOut   <= countSample;
              countValid <= 1'b1;
              startPulse <= 1'b1;
              phase      <= PH_DONE;
            end else begin
              stableCnt <= stableCnt + 1'b1;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign busy          = (phase == PH_GATE) || (phase == PH_DRAIN) || (phase == PH_SETTLE);
  assign measCtl.clear = clearLvl;
  assign measCtl.gate  = gateLvl;
  assign calcCtl.start = startPulse;
  assign calcCtl.flush = wrClear || startGo;

endmodule

// File: rtl/freqmeter_datapath.sv
module freqmeter_datapath
  import freqmeter_pkg::*;
#(
  parameter int COUNT_W     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               measClk,
  input  logic               rstN,
  input  measCtl_t           measCtl,
  output logic [COUNT_W-1:0] measCount,
  output logic               measDone
);

  localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

  logic [1:0] ctlS;
  logic       clearS;
  logic       gateS;
  logic       gatePrev;
  logic       frozen;

  freqmeter_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) ctlSync_i (
    .clk (measClk),
    .rstN(rstN),
    .din ({measCtl.clear, measCtl.gate}),
    .dout(ctlS)
  );

  assign clearS = ctlS[1];
  assign gateS  = ctlS[0];

  always_ff @(posedge measClk or negedge rstN) begin
    if (!rstN) begin
      measCount <= '0;
      measDone  <= 1'b0;
      frozen    <= 1'b0;
      gatePrev  <= 1'b0;
    end else begin
      gatePrev <= gateS;
      if (clearS) begin
        measCount <= '0;
        measDone  <= 1'b0;
        frozen    <= 1'b0;
      end else begin
        if (gateS && !frozen && (measCount != CNT_MAX)) measCount <= measCount + 1'b1;
        if (gateS && !gatePrev) measDone <= 1'b0;
        if (!gateS && gatePrev) begin
          frozen   <= 1'b1;
          measDone <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/freqmeter_khz.sv
module freqmeter_khz
  import freqmeter_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int WIN_W   = 16,
  parameter int REF_KHZ = 100000,
  parameter int FREQ_W  = 32,
  parameter int KHZ_EN  = 1
) (
  input  logic               refClk,
  input  logic               rstN,
  input  calcCtl_t           calcCtl,
  input  logic [COUNT_W-1:0] countIn,
  input  logic [WIN_W-1:0]   winIn,
  output logic               freqValid,
  output logic [FREQ_W-1:0]  freqKhz
);

  localparam int REF_W = $clog2(REF_KHZ + 1);
  localparam int NUM_W = COUNT_W + REF_W;
  localparam int IDX_W = $clog2(NUM_W + 1);

  generate
    if (KHZ_EN != 0) begin : g_calc
      logic [NUM_W-1:0]  work;
      logic [WIN_W-1:0]  rem;
      logic [WIN_W-1:0]  divisor;
      logic [IDX_W-1:0]  left;
      logic              running;
      logic              valid;
      logic [WIN_W:0]    remShift;
      logic              take;
      logic [FREQ_W-1:0] quot;

      always_comb begin
        remShift = {rem, work[NUM_W-1]};
        take     = remShift >= {1'b0, divisor};
      end

      // restoring division, one quotient bit per reference cycle
      always_ff @(posedge refClk or negedge rstN) begin
        if (!rstN) begin
          work    <= '0;
          rem     <= '0;
          divisor <= '0;
          left    <= '0;
          running <= 1'b0;
          valid   <= 1'b0;
        end else if (calcCtl.flush) begin
          running <= 1'b0;
          valid   <= 1'b0;
        end else if (calcCtl.start) begin
          work    <= NUM_W'(countIn) * NUM_W'(REF_KHZ);
          rem     <= '0;
          divisor <= winIn;
          left    <= IDX_W'(NUM_W);
          running <= 1'b1;
          valid   <= 1'b0;
        end else if (running) begin
          rem  <= take ? WIN_W'(remShift - {1'b0, divisor}) : WIN_W'(remShift);
          work <= {work[NUM_W-2:0], take};
          left <= left - 1'b1;
          if (left == IDX_W'(1)) begin
            running <= 1'b0;
            valid   <= 1'b1;
          end
        end
      end

      if (NUM_W > FREQ_W) begin : g_cap
        assign quot = (|work[NUM_W-1:FREQ_W]) ? {FREQ_W{1'b1}} : work[FREQ_W-1:0];
      end else begin : g_wide
        assign quot = FREQ_W'(work);
      end

      assign freqValid = valid;
      assign freqKhz   = valid ? quot : '0;
    end else begin : g_none
      assign freqValid = 1'b0;
      assign freqKhz   = '0;
    end
  endgenerate

endmodule

// File: rtl/refgated_freq_meter.sv
module refgated_freq_meter
  import freqmeter_pkg::*;
#(
  parameter int COUNT_W     = 32,
  parameter int WIN_W       = 16,
  parameter int DEF_WINDOW  = 100,
  parameter int REF_KHZ     = 100000,
  parameter int FREQ_W      = 32,
  parameter int KHZ_EN      = 1,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 2
) (
  input  logic               refClk,
  input  logic               measClk,
  input  logic               rstN,
  input  logic               cfgWrite,
  input  logic [WIN_W+2:0]   cfgData,
  output logic               busy,
  output logic               countValid,
  output logic [COUNT_W-1:0] countOut,
  output logic               freqValid,
  output logic [FREQ_W-1:0]  freqKhz
);

  measCtl_t           measCtl;
  calcCtl_t           calcCtl;
  logic [COUNT_W-1:0] measCount;
  logic               measDone;
  logic [WIN_W-1:0]   activeWin;

  freqmeter_ctrl #(
    .COUNT_W    (COUNT_W),
    .WIN_W      (WIN_W),
    .DEF_WINDOW (DEF_WINDOW),
    .SETTLE_CYC (SETTLE_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .refClk    (refClk),
    .rstN      (rstN),
    .cfgWrite  (cfgWrite),
    .cfgData   (cfgData),
    .measDone  (measDone),
    .measCount (measCount),
    .measCtl   (measCtl),
    .calcCtl   (calcCtl),
    .busy      (busy),
    .countValid(countValid),
    .countOut  (countOut),
    .activeWin (activeWin)
  );

  freqmeter_datapath #(
    .COUNT_W    (COUNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .measClk  (measClk),
    .rstN     (rstN),
    .measCtl  (measCtl),
    .measCount(measCount),
    .measDone (measDone)
  );

  freqmeter_khz #(
    .COUNT_W(COUNT_W),
    .WIN_W  (WIN_W),
    .REF_KHZ(REF_KHZ),
    .FREQ_W (FREQ_W),
    .KHZ_EN (KHZ_EN)
  ) khz_i (
    .refClk   (refClk),
    .rstN     (rstN),
    .calcCtl  (calcCtl),
    .countIn  (countOut),
    .winIn    (activeWin),
    .freqValid(freqValid),
    .freqKhz  (freqKhz)
  );

endmodule

// File: rtl/freqmeter_chk.sv
module freqmeter_chk #(
  parameter int COUNT_W = 32
) (
  input logic               refClk,
  input logic               measClk,
  input logic               rstN,
  input logic               cfgWrite,
  input logic               cfgClear,
  input logic               busy,
  input logic               countValid,
  input logic [COUNT_W-1:0] countOut,
  input logic               freqValid,
  input logic               measClear,
  input logic [COUNT_W-1:0] measCount
);

  // R5
  busy_excl_chk: assert property (@(posedge refClk) disable iff (!rstN)
    countValid |-> !busy);

  // R5
  busy_hold_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (busy && !(cfgWrite && cfgClear)) |=> (busy || countValid));

  // R6
  result_hold_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (countValid && !cfgWrite) |=> (countOut == $past(countOut)));

  // R2
  clear_empty_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (cfgWrite && cfgClear) |=> (!countValid && !freqValid && (countOut == '0)));

  // R9
  freq_order_chk: assert property (@(posedge refClk) disable iff (!rstN)
    freqValid |-> countValid);

  // R8
  no_wrap_chk: assert property (@(posedge measClk) disable iff (!rstN)
    ((measCount == {COUNT_W{1'b1}}) && !measClear) |=> (measCount == {COUNT_W{1'b1}}));

endmodule

bind refgated_freq_meter freqmeter_chk #(.COUNT_W(COUNT_W)) chk_i (
  .refClk    (refClk),
  .measClk   (measClk),
  .rstN      (rstN),
  .cfgWrite  (cfgWrite),
  .cfgClear  (cfgData[0]),
  .busy      (busy),
  .countValid(countValid),
  .countOut  (countOut),
  .freqValid (freqValid),
  .measClear (measCtl.clear),
  .measCount (measCount)
);

// File: tb/refgated_freq_meter_tb.sv
module refgated_freq_meter_tb_top;

  localparam int WIN_W   = 16;
  localparam int COUNT_W = 32;
  localparam int FREQ_W  = 32;
  localparam int SAT_W   = 8;

  typedef struct {
    longint cnt;
    longint khz;
    string  tag;
  } expItem_t;

  logic refClk = 1'b0;
  logic measClk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrite = 1'b0;
  logic [WIN_W+2:0] cfgData = '0;
  logic busy, countValid, freqValid;
  logic [COUNT_W-1:0] countOut;
  logic [FREQ_W-1:0] freqKhz;

  logic satWrite = 1'b0;
  logic [WIN_W+2:0] satData = '0;
  logic satBusy, satValid, satFreqValid;
  logic [SAT_W-1:0] satCount;
  logic [FREQ_W-1:0] satKhz;

  int checks = 0;
  int errors = 0;
  int pending = 0;
  bit finished = 0;
  expItem_t sbQ[$];

  // 100 MHz reference (rising edges at odd ns), 250 MHz measured clock (even ns)
  always #5 refClk = ~refClk;
  always #2 measClk = ~measClk;

  refgated_freq_meter dut_i (
    .refClk(refClk), .measClk(measClk), .rstN(rstN),
    .cfgWrite(cfgWrite), .cfgData(cfgData),
    .busy(busy), .countValid(countValid), .countOut(countOut),
    .freqValid(freqValid), .freqKhz(freqKhz)
  );

  refgated_freq_meter #(.COUNT_W(SAT_W)) satDut_i (
    .refClk(refClk), .measClk(measClk), .rstN(rstN),
    .cfgWrite(satWrite), .cfgData(satData),
    .busy(satBusy), .countValid(satValid), .countOut(satCount),
    .freqValid(satFreqValid), .freqKhz(satKhz)
  );

  function automatic logic [WIN_W+2:0] mk(bit clr, bit en, bit we, int win);
    return {WIN_W'(win), we, en, clr};
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(logic [WIN_W+2:0] v);
    @(negedge refClk);
    cfgWrite = 1'b1;
    cfgData  = v;
    @(negedge refClk);
    cfgWrite = 1'b0;
    cfgData  = '0;
  endtask

  task automatic pushExp(longint c, longint k, string tag);
    expItem_t it;
    it.cnt = c;
    it.khz = k;
    it.tag = tag;
    sbQ.push_back(it);
    pending++;
  endtask

  task automatic runMeas(logic [WIN_W+2:0] v, longint c, longint k, string tag);
    pushExp(c, k, tag);
    writeCfg(v);
    check(busy == 1'b1, {tag, " R5 busy after start"}, longint'(busy), 1);
    wait (pending == 0);
  endtask

  // monitor: pops expected results as the design publishes them
  initial begin
    bit prevV = 0;
    forever begin
      @(negedge refClk);
      if (countValid && !prevV) begin
        expItem_t it;
        logic [COUNT_W-1:0] firstRead;
        if (sbQ.size() == 0) begin
          check(1'b0, "R5 unexpected result", longint'(countOut), 0);
        end else begin
          it = sbQ.pop_front();
          firstRead = countOut;
          check(countOut == COUNT_W'(it.cnt), {it.tag, " count"}, longint'(countOut), it.cnt);
          for (int i = 0; i < 400 && !freqValid; i++) @(negedge refClk);
          check(freqValid && (freqKhz == FREQ_W'(it.khz)), {it.tag, " R9 kHz"},
                longint'(freqKhz), it.khz);
          repeat (25) @(negedge refClk);
          check(countOut == firstRead, {it.tag, " R6 second read"},
                longint'(countOut), longint'(firstRead));
          pending--;
        end
      end
      prevV = countValid;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge refClk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge refClk);
    rstN = 1'b1;
    @(negedge refClk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", longint'(busy), 0);
    check(countValid == 1'b0, "R1 countValid", longint'(countValid), 0);
    check(countOut == '0, "R1 countOut", longint'(countOut), 0);
    check(freqValid == 1'b0, "R1 freqValid", longint'(freqValid), 0);

    // R1 R4: default window of 100 -> 250 edges
    writeCfg(mk(1, 0, 0, 0));
    runMeas(mk(0, 1, 0, 0), 250, 250000, "R1 R4 default window");

    // R3: window-only write loads 20 but does not start
    writeCfg(mk(0, 0, 1, 20));
    check(busy == 1'b0, "R3 window write starts nothing", longint'(busy), 0);
    check(countValid == 1'b1, "R3 result kept", longint'(countValid), 1);
    writeCfg(mk(1, 0, 0, 0));
    pushExp(50, 250000, "R3 stored window 20");
    writeCfg(mk(0, 1, 0, 0));
    // R5: write while busy is ignored (window 2 would give 5)
    writeCfg(mk(0, 1, 1, 2));
    check(busy == 1'b1, "R5 still busy after ignored write", longint'(busy), 1);
    wait (pending == 0);

    // R2: clear empties result
    writeCfg(mk(1, 0, 0, 0));
    check(countValid == 1'b0, "R2 countValid cleared", longint'(countValid), 0);
    check(countOut == '0, "R2 countOut cleared", longint'(countOut), 0);
    check(freqValid == 1'b0, "R2 freqValid cleared", longint'(freqValid), 0);

    // R4: explicit window 40 -> 100 edges
    runMeas(mk(0, 1, 1, 40), 100, 250000, "R4 window 40");

    // R7: restart without clear keeps the frozen 100, new window 100
    runMeas(mk(0, 1, 1, 100), 100, 100000, "R7 restart no clear");

    // R3: zero window field ignored, stored 100 stays
    writeCfg(mk(1, 0, 0, 0));
    runMeas(mk(0, 1, 1, 0), 250, 250000, "R3 zero window ignored");

    // R8: 8-bit counter, window 200 -> 500 edges saturates at 255
    @(negedge refClk);
    satWrite = 1'b1; satData = mk(1, 0, 0, 0);
    @(negedge refClk);
    satData = mk(0, 1, 1, 200);
    @(negedge refClk);
    satWrite = 1'b0; satData = '0;
    for (int i = 0; i < 1000 && !satValid; i++) @(negedge refClk);
    check(satValid && (satCount == 8'hFF), "R8 saturated count", longint'(satCount), 255);
    for (int i = 0; i < 400 && !satFreqValid; i++) @(negedge refClk);
    check(satFreqValid && (satKhz == 32'd127500), "R8 R9 saturated kHz",
          longint'(satKhz), 127500);

    finished = 1;
    summary();
    $finish;
  end

endmodule